// File: doc/BRIEF.md
# Maskable Interrupt Status Aggregator

This block gathers two groups of event sources into status registers: six DMA completion and idle events and a small group of user events. It gates each status bit with its own mask bit and presents one interrupt request to the host link. A 32-bit register port lets software read status, masks and the mode, clear status, and program masks.

In legacy mode the status bits are sticky. Software clears a bit by writing 1 to its position. The request is a level that stays high while any unmasked status bit is set. In message mode a one-cycle send strobe goes out. When the link acknowledges the send, exactly the bits that caused that message clear themselves. Events that arrive while a message is outstanding are held and folded into a single follow-up message, so one request covers every event raised since the last one was serviced.

Sources are active high and may be pulses or held levels. Each status bit is captured on the rising edge of its source.

Top module: `irq_collect`

## Requirements
- R1: After reset all status bits, both masks and the mode bit read 0, and `irq_level` and `irq_send` are low.
- R2: A rising edge on a source sets its status bit on the next clock. A source held high sets the bit only once. After that bit is cleared it stays clear until the source goes low and then high again.
- R3: Register word offsets: 0x00 DMA status, 0x04 DMA mask, 0x08 user status, 0x0C user mask, 0x10 mode (bit 0: 0 = legacy, 1 = message). DMA status bits, LSB first: engine 0 to-host done, engine 0 from-host done, engine 1 to-host done, engine 1 from-host done, engine 0 going idle, engine 1 going idle. User status bit n follows `usr_evt[n]`.
- R4: In legacy mode, writing to a status offset clears the bits written as 1 and leaves the others unchanged. A source edge in the same cycle as the clear wins.
- R5: A status bit whose mask bit is 0 is still recorded but creates no request. A mask bit of 1 lets its status bit request.
- R6: In legacy mode `irq_level` equals the OR of all masked status bits, one cycle after the status change. `irq_send` stays low.
- R7: In message mode, when no message is outstanding and any masked status bit is set, `irq_send` pulses for exactly one cycle and a message becomes outstanding. `irq_level` stays low.
- R8: In message mode, `send_ack` while a message is outstanding clears exactly the masked status bits that were pending when it was sent. Bits set after the send remain and raise one new strobe after the acknowledge. `send_ack` with nothing outstanding is ignored.
- R9: While a message is outstanding no further strobe is issued. In message mode, writes to the status offsets have no effect.
- R10: Reads return the addressed register one clock after the address is applied. Masks keep only their implemented bits, the mode keeps bit 0 only, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_evt | input | 6 | DMA event sources |
| usr_evt | input | 4 | User event sources |
| send_ack | input | 1 | Link has sent the outstanding interrupt message |
| reg_addr | input | 5 | Register byte offset |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_level | output | 1 | Legacy level request |
| irq_send | output | 1 | Message-mode one-cycle send strobe |

## Verification
The hardest state to reach from the ports is a message-mode window in which one message is outstanding, new events are landing on bits not in its snapshot, and an acknowledge then removes only part of the status. At that point exactly one follow-up strobe must appear. A directed sequence builds this window: it holds a user level, pulses a second source while the first message is unacknowledged, tries a write-one clear, and then acknowledges. Long random stretches then mix sparse events, random acknowledges, mask rewrites and occasional mode flips against a cycle model kept in the bench. This puts an acknowledge in the same cycle as a new edge and flips the mode with a message outstanding.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W = 32;
  // register word indices (byte offset >> 2)
  localparam logic [2:0] W_DSTS  = 3'd0;
  localparam logic [2:0] W_DMASK = 3'd1;
  localparam logic [2:0] W_USTS  = 3'd2;
  localparam logic [2:0] W_UMASK = 3'd3;
  localparam logic [2:0] W_MODE  = 3'd4;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status
);
  logic [W-1:0] prev_q;
  logic [W-1:0] status_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[i]   <= 1'b0;
        status_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= evt[i];
        if (evt[i] && !prev_q[i]) status_q[i] <= 1'b1;
        else if (clr[i])          status_q[i] <= 1'b0;
      end
    end

    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
      (!status_q[i] && !evt[i]) |=> !status_q[i]);
    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (status_q[i] && !clr[i]) |=> status_q[i]);
  end

  assign status = status_q;
endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         msg_mode,
  input  logic [N-1:0] pend,
  input  logic         send_ack,
  output logic [N-1:0] ack_clr,
  output logic         irq_level,
  output logic         irq_send
);
  logic         out_q;
  logic [N-1:0] snap_q;
  logic         send_q;
  logic         lvl_q;
  logic         ack_fire;

  assign ack_fire = msg_mode && out_q && send_ack;
  assign ack_clr  = ack_fire ? snap_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= 1'b0;
      snap_q <= '0;
      send_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      send_q <= 1'b0;
      lvl_q  <= !msg_mode && (|pend);
      if (!msg_mode) begin
        out_q <= 1'b0;
      end else if (out_q) begin
        if (send_ack) out_q <= 1'b0;
      end else if (|pend) begin
        out_q  <= 1'b1;
        send_q <= 1'b1;
        snap_q <= pend;
      end
    end
  end

  assign irq_level = lvl_q;
  assign irq_send  = send_q;

  // R7
  send_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    irq_send |=> !irq_send);
  // R7
  send_not_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_send |-> !irq_level);
  // R9
  coalesce_chk: assert property (@(posedge clk) disable iff (rst)
    (out_q && !send_ack) |=> !irq_send);
endmodule

// File: rtl/irq_collect.sv
module irq_collect
  import irq_pkg::*;
#(
  parameter int DMA_N  = 6,
  parameter int USR_N  = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DMA_N-1:0]  dma_evt,
  input  logic [USR_N-1:0]  usr_evt,
  input  logic              send_ack,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_level,
  output logic              irq_send
);
  localparam int TOT_N = DMA_N + USR_N;

  logic [DMA_N-1:0]  dsts, dmask_q, dclr;
  logic [USR_N-1:0]  usts, umask_q, uclr;
  logic              mode_q;
  logic [TOT_N-1:0]  pend, ack_clr;
  logic [2:0]        widx;
  logic [DATA_W-1:0] rd_q;
  logic              unused_bits;

  assign widx = reg_addr[4:2];
  assign unused_bits = ^{reg_addr[1:0], reg_wdata};

  always_comb begin
    dclr = ack_clr[DMA_N-1:0];
    uclr = ack_clr[TOT_N-1:DMA_N];
    if (reg_we && !mode_q && widx == W_DSTS) dclr = dclr | reg_wdata[DMA_N-1:0];
    if (reg_we && !mode_q && widx == W_USTS) uclr = uclr | reg_wdata[USR_N-1:0];
  end

  irq_src_bank #(.W(DMA_N)) u_dma_bank (
    .clk(clk), .rst(rst), .evt(dma_evt), .clr(dclr), .status(dsts));

  irq_src_bank #(.W(USR_N)) u_usr_bank (
    .clk(clk), .rst(rst), .evt(usr_evt), .clr(uclr), .status(usts));

  assign pend = {usts & umask_q, dsts & dmask_q};

  irq_req_ctrl #(.N(TOT_N)) u_req (
    .clk(clk), .rst(rst), .msg_mode(mode_q), .pend(pend),
    .send_ack(send_ack), .ack_clr(ack_clr),
    .irq_level(irq_level), .irq_send(irq_send));

  always_ff @(posedge clk) begin
    if (rst) begin
      dmask_q <= '0;
      umask_q <= '0;
      mode_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      case (widx)
        W_DSTS:  rd_q <= {{(DATA_W-DMA_N){1'b0}}, dsts};
        W_DMASK: rd_q <= {{(DATA_W-DMA_N){1'b0}}, dmask_q};
        W_USTS:  rd_q <= {{(DATA_W-USR_N){1'b0}}, usts};
        W_UMASK: rd_q <= {{(DATA_W-USR_N){1'b0}}, umask_q};
        W_MODE:  rd_q <= {{(DATA_W-1){1'b0}}, mode_q};
        default: rd_q <= '0;
      endcase
      if (reg_we) begin
        if (widx == W_DMASK) dmask_q <= reg_wdata[DMA_N-1:0];
        if (widx == W_UMASK) umask_q <= reg_wdata[USR_N-1:0];
        if (widx == W_MODE)  mode_q  <= reg_wdata[0];
      end
    end
  end

  assign reg_rdata = rd_q;

  // R6
  legacy_no_send_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_q) |=> !irq_send);
endmodule

// File: tb/irq_collect_bench.sv
module irq_collect_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  dma_evt = '0;
  logic [3:0]  usr_evt = '0;
  logic        send_ack = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_level, irq_send;

  int nvec = 0;
  int nerr = 0;
  int nsend = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_collect u_irq_collect (
    .clk(clk), .rst(rst), .dma_evt(dma_evt), .usr_evt(usr_evt),
    .send_ack(send_ack), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_level(irq_level), .irq_send(irq_send));

  // reference model built from the requirements
  logic [5:0]  m_dsts, m_dmask, m_pd, m_clrd;
  logic [3:0]  m_usts, m_umask, m_pu, m_clru;
  logic        m_mode, m_out, m_send, m_lvl;
  logic [9:0]  m_snap, m_pend;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_dsts = 0; m_dmask = 0; m_pd = 0; m_usts = 0; m_umask = 0; m_pu = 0;
      m_mode = 0; m_out = 0; m_send = 0; m_lvl = 0; m_snap = 0; m_rd = 0;
    end else begin
      m_pend = {m_usts & m_umask, m_dsts & m_dmask};
      case (reg_addr[4:2])
        3'd0: m_rd = {26'd0, m_dsts};
        3'd1: m_rd = {26'd0, m_dmask};
        3'd2: m_rd = {28'd0, m_usts};
        3'd3: m_rd = {28'd0, m_umask};
        3'd4: m_rd = {31'd0, m_mode};
        default: m_rd = 0;
      endcase
      m_clrd = 0; m_clru = 0;
      if (m_mode && m_out && send_ack) {m_clru, m_clrd} = m_snap;
      if (!m_mode && reg_we && reg_addr[4:2] == 3'd0) m_clrd = reg_wdata[5:0];
      if (!m_mode && reg_we && reg_addr[4:2] == 3'd2) m_clru = reg_wdata[3:0];
      m_dsts = (m_dsts & ~m_clrd) | (dma_evt & ~m_pd); m_pd = dma_evt;
      m_usts = (m_usts & ~m_clru) | (usr_evt & ~m_pu); m_pu = usr_evt;
      m_send = 0;
      m_lvl = !m_mode && (|m_pend);
      if (!m_mode) m_out = 0;
      else if (m_out) begin if (send_ack) m_out = 0; end
      else if (|m_pend) begin m_out = 1; m_send = 1; m_snap = m_pend; end
      if (reg_we && reg_addr[4:2] == 3'd1) m_dmask = reg_wdata[5:0];
      if (reg_we && reg_addr[4:2] == 3'd3) m_umask = reg_wdata[3:0];
      if (reg_we && reg_addr[4:2] == 3'd4) m_mode = reg_wdata[0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the model, away from the clock edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6 irq_level", {31'd0, irq_level}, {31'd0, m_lvl});
      chk("R7 irq_send", {31'd0, irq_send}, {31'd0, m_send});
      chk("R10 reg_rdata", reg_rdata, m_rd);
    end
    if (irq_send) nsend++;
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int s0;
    void'($urandom(32'h5eed_1234));
    idle(3); rst = 0; @(negedge clk);

    // R1 reset state
    rd(5'h00, d); chk("R1 dma status", d, 0);
    rd(5'h04, d); chk("R1 dma mask", d, 0);
    rd(5'h08, d); chk("R1 user status", d, 0);
    rd(5'h0C, d); chk("R1 user mask", d, 0);
    rd(5'h10, d); chk("R1 mode", d, 0);
    chk("R1 outputs", {30'd0, irq_level, irq_send}, 0);

    // R10 mask width, unmapped offset
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, d); chk("R10 dma mask width", d, 32'h3F);
    rd(5'h14, d); chk("R10 unmapped", d, 0);

    // R3 engine 0 going-idle is status bit 4; R6 level follows
    dma_evt[4] = 1; @(negedge clk); dma_evt[4] = 0;
    rd(5'h00, d); chk("R3 idle0 bit", d, 32'h10);
    chk("R6 level high", {31'd0, irq_level}, 1);

    // R2 held level sets once, not again after clear
    usr_evt[2] = 1; idle(3);
    rd(5'h08, d); chk("R2 user bit set", d, 32'h4);
    wr(5'h08, 32'h4); idle(2);
    rd(5'h08, d); chk("R2 held level no re-set", d, 0);
    usr_evt[2] = 0; @(negedge clk); usr_evt[2] = 1; @(negedge clk);
    rd(5'h08, d); chk("R2 re-arm after low", d, 32'h4);

    // R4 partial clear, R5 masked user bit gives no request
    wr(5'h00, 32'h3F); idle(1);
    rd(5'h00, d); chk("R4 clear written bits", d, 0);
    rd(5'h08, d); chk("R4 other register untouched", d, 32'h4);
    chk("R5 masked bit no request", {31'd0, irq_level}, 0);
    dma_evt[1] = 1; wr(5'h00, 32'h2); dma_evt[1] = 0;
    rd(5'h00, d); chk("R4 edge beats clear", d, 32'h2);
    wr(5'h00, 32'h2);

    // R7 message mode
    wr(5'h10, 32'h1);
    s0 = nsend;
    wr(5'h0C, 32'hF); idle(4);
    chk("R7 one strobe", nsend - s0, 1);
    chk("R7 no level in message mode", {31'd0, irq_level}, 0);
    // R9 coalesce while outstanding
    usr_evt[0] = 1; @(negedge clk); usr_evt[0] = 0; idle(3);
    chk("R9 no strobe while outstanding", nsend - s0, 1);
    wr(5'h08, 32'hF);
    rd(5'h08, d); chk("R9 write ignored in message mode", d, 32'h5);
    // R8 ack clears only the snapshot, one follow-up strobe
    send_ack = 1; @(negedge clk); send_ack = 0;
    rd(5'h08, d); chk("R8 snapshot cleared", d, 32'h1);
    idle(3);
    chk("R8 follow-up strobe", nsend - s0, 2);
    send_ack = 1; @(negedge clk); send_ack = 0; idle(2);
    send_ack = 1; @(negedge clk); send_ack = 0;
    rd(5'h08, d); chk("R8 stray ack ignored", d, 0);
    usr_evt = 0;

    // random phase
    for (int c = 0; c < 5000; c++) begin
      dma_evt  = $urandom & $urandom & $urandom;
      usr_evt  = ($urandom % 3 == 0) ? 4'($urandom) : usr_evt;
      send_ack = ($urandom % 5 == 0);
      reg_addr = 5'(($urandom % 6) << 2);
      reg_wdata = $urandom;
      reg_we = ($urandom % 4 == 0);
      if (reg_we && reg_addr == 5'h10 && ($urandom % 8 != 0)) reg_we = 0;
      @(negedge clk);
    end
    reg_we = 0; send_ack = 0;
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule